// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit sits beside the decode stage of a five-stage in-order pipeline and settles every conditional branch and jump while the instruction is still in decode. It reads one register operand from the register file, checks whether that value is zero or nonzero, and adds the sign-extended offset to the address of the following instruction on a private adder. Because the outcome is known one stage after fetch, a control transfer costs only one fetch slot. That slot is architected as a delay slot: the instruction fetched right after a branch or jump always executes, and the redirect takes effect on the fetch after it.

The fetch stage supplies its current PC and its already incremented sequential PC. The unit returns the PC that fetch must use next, a redirect flag, and a stall flag. The unit does not forward operands into decode. If the tested register is still being produced by the instruction in execute, or by a load in the memory stage, the unit stalls decode and holds fetch in place until the value can be read. A jump that links also gives the register-file write port a return address that skips the delay slot.

Control is a three-state machine. `ST_RUN` is the normal state, in which decode is evaluated. `ST_WAIT` holds a stalled branch. `ST_SLOT` marks that the next valid decode instruction is a delay slot. Transitions: RUN→WAIT and WAIT→WAIT when a valid branch meets a hazard. RUN→SLOT and WAIT→SLOT when a valid branch or jump resolves. RUN→RUN on anything else, and WAIT→RUN when decode turns invalid. SLOT→RUN when a valid instruction is presented, and SLOT→SLOT while decode is invalid.

Top module: `id_branch_unit`

## Requirements
- R1: When reset is released, with decode idle: redirect, stall and link write are all 0, and next_pc equals if_seq_pc.
- R2: The opcode sits in instruction bits 31:26. The control opcodes are 0x04 (branch if zero), 0x05 (branch if nonzero), 0x02 (jump) and 0x03 (jump and link). Any other opcode gives redirect 0, stall 0 and next_pc = if_seq_pc.
- R3: The tested register index is instruction bits 25:21 and is always driven on rs_idx. A branch-if-zero whose rs_val is 0 gives redirect 1 and next_pc = id_pc + 4 + sign-extended bits 15:0.
- R4: A branch-if-nonzero is taken when rs_val is nonzero, with the same target as R3. A branch whose condition fails gives redirect 0 and next_pc = if_seq_pc.
- R5: A jump always redirects to id_pc + 4 + sign-extended bits 25:0.
- R6: A jump-and-link redirects as in R5 and also gives link_we 1, link_idx 31 and link_data = id_pc + 8.
- R7: A branch whose tested register matches ex_rd while ex_wr_en is 1, or matches mem_rd while mem_load is 1, gives stall 1, redirect 0 and next_pc = if_pc. It keeps doing so each cycle until the match clears, and then resolves as in R3 or R4.
- R8: A tested register of index 0 never stalls, and a jump never stalls, whatever the execute and memory stages hold.
- R9: The first valid instruction after a resolved branch or jump (taken or not) is a delay slot. It gives no redirect, no stall and no link write, even if it is itself a control opcode.
- R10: While id_valid is 0 there is no redirect, stall or link write. A pending delay slot stays pending until a valid instruction arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode holds a valid instruction |
| id_instr | input | 32 | Instruction in decode |
| id_pc | input | 32 | Address of the decode instruction |
| if_pc | input | 32 | Current fetch address (delay slot) |
| if_seq_pc | input | 32 | Fetch address plus 4, computed in fetch |
| rs_val | input | 32 | Register-file value of the tested register |
| ex_wr_en | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | 5 | Execute-stage destination register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage load destination |
| rs_idx | output | 5 | Tested register index to the register file |
| stall | output | 1 | Hold decode and fetch |
| redirect | output | 1 | next_pc is a control-transfer target |
| next_pc | output | 32 | Address fetch uses next |
| link_we | output | 1 | Write the return address |
| link_idx | output | 5 | Return-address register index |
| link_data | output | 32 | Return address |

## Verification
The hardest case to reach from the ports is a branch that stalls for several cycles, is then released, and is followed by a control opcode in its delay slot. To reach it, the stimulus holds the same decode inputs while the execute or load match is present, removes the match, and then presents a branch whose condition would be taken as the slot instruction. A second hard case is a delay slot split from its branch by invalid decode cycles. The stimulus inserts idle cycles before the slot instruction to show that the pending slot survives them.

// File: rtl/ibu_pkg.sv
package ibu_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_SLOT = 2'd2
    } ibu_state_e;

    typedef enum logic [2:0] {
        CT_NONE  = 3'd0,
        CT_BEQZ  = 3'd1,
        CT_BNEZ  = 3'd2,
        CT_JUMP  = 3'd3,
        CT_JLINK = 3'd4
    } ibu_kind_e;

    localparam logic [5:0] OP_BEQZ  = 6'h04;
    localparam logic [5:0] OP_BNEZ  = 6'h05;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_JLINK = 6'h03;

endpackage

// File: rtl/ibu_decode.sv
module ibu_decode
    import ibu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int BOFS_W = 16,
    parameter int JOFS_W = 26
) (
    input  logic [31:0]      instr,
    output ibu_kind_e        kind,
    output logic [REG_W-1:0] rs,
    output logic [XLEN-1:0]  offset
);
    localparam int OP_LSB = 26;
    localparam int RS_LSB = 21;

    logic [5:0]      opcode;
    logic [XLEN-1:0] br_ofs;
    logic [XLEN-1:0] j_ofs;

    assign opcode = instr[OP_LSB +: 6];
    assign rs     = instr[RS_LSB +: REG_W];
    assign br_ofs = {{(XLEN-BOFS_W){instr[BOFS_W-1]}}, instr[BOFS_W-1:0]};
    assign j_ofs  = {{(XLEN-JOFS_W){instr[JOFS_W-1]}}, instr[JOFS_W-1:0]};

    always_comb begin
        unique case (opcode)
            OP_BEQZ:  kind = CT_BEQZ;
            OP_BNEZ:  kind = CT_BNEZ;
            OP_JUMP:  kind = CT_JUMP;
            OP_JLINK: kind = CT_JLINK;
            default:  kind = CT_NONE;
        endcase
    end

    assign offset = (kind == CT_JUMP || kind == CT_JLINK) ? j_ofs : br_ofs;

endmodule

// File: rtl/ibu_target.sv
module ibu_target #(
    parameter int XLEN      = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] ret_addr
);
    localparam logic [XLEN-1:0] STEP1 = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

    logic [XLEN-1:0] slot_pc;

    assign slot_pc  = pc + STEP1;
    assign target   = slot_pc + offset;
    assign ret_addr = pc + STEP2;

endmodule

// File: rtl/ibu_hazard.sv
module ibu_hazard #(
    parameter int REG_W   = 5,
    parameter bit ZERO_R0 = 1'b1
) (
    input  logic [REG_W-1:0] rs,
    input  logic             ex_wr_en,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_load,
    input  logic [REG_W-1:0] mem_rd,
    output logic             hit
);
    logic raw_hit;

    assign raw_hit = (ex_wr_en && (ex_rd == rs)) || (mem_load && (mem_rd == rs));

    generate
        if (ZERO_R0) begin : g_r0_const
            assign hit = raw_hit && (rs != '0);
        end else begin : g_r0_plain
            assign hit = raw_hit;
        end
    endgenerate

endmodule

// File: rtl/id_branch_unit.sv
module id_branch_unit
    import ibu_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REG_W    = 5,
    parameter int LINK_REG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_valid,
    input  logic [31:0]      id_instr,
    input  logic [XLEN-1:0]  id_pc,
    input  logic [XLEN-1:0]  if_pc,
    input  logic [XLEN-1:0]  if_seq_pc,
    input  logic [XLEN-1:0]  rs_val,
    input  logic             ex_wr_en,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             mem_load,
    input  logic [REG_W-1:0] mem_rd,
    output logic [REG_W-1:0] rs_idx,
    output logic             stall,
    output logic             redirect,
    output logic [XLEN-1:0]  next_pc,
    output logic             link_we,
    output logic [REG_W-1:0] link_idx,
    output logic [XLEN-1:0]  link_data
);
    localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

    ibu_state_e      state_q, state_d;
    ibu_kind_e       kind;
    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] ret_addr;
    logic            dep_hit;
    logic            is_ctl;
    logic            is_branch;
    logic            hazard;
    logic            cond_true;

    ibu_decode #(.XLEN(XLEN), .REG_W(REG_W)) u_dec (
        .instr  (id_instr),
        .kind   (kind),
        .rs     (rs_idx),
        .offset (offset)
    );

    ibu_target #(.XLEN(XLEN)) u_tgt (
        .pc       (id_pc),
        .offset   (offset),
        .target   (target),
        .ret_addr (ret_addr)
    );

    ibu_hazard #(.REG_W(REG_W)) u_haz (
        .rs       (rs_idx),
        .ex_wr_en (ex_wr_en),
        .ex_rd    (ex_rd),
        .mem_load (mem_load),
        .mem_rd   (mem_rd),
        .hit      (dep_hit)
    );

    assign is_ctl    = id_valid && (kind != CT_NONE);
    assign is_branch = is_ctl && (kind == CT_BEQZ || kind == CT_BNEZ);
    assign hazard    = is_branch && dep_hit;

    always_comb begin
        unique case (kind)
            CT_BEQZ:           cond_true = (rs_val == '0);
            CT_BNEZ:           cond_true = (rs_val != '0);
            CT_JUMP, CT_JLINK: cond_true = 1'b1;
            default:           cond_true = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN, ST_WAIT: begin
                if (hazard) begin
                    state_d = ST_WAIT;
                end else if (is_ctl) begin
                    state_d = ST_SLOT;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_SLOT: begin
                if (id_valid) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        stall     = 1'b0;
        redirect  = 1'b0;
        link_we   = 1'b0;
        link_idx  = LINK_IDX;
        link_data = ret_addr;
        next_pc   = if_seq_pc;
        unique case (state_q)
            ST_RUN, ST_WAIT: begin
                stall    = hazard;
                redirect = is_ctl && !hazard && cond_true;
                link_we  = is_ctl && (kind == CT_JLINK);
                if (hazard) begin
                    next_pc = if_pc;
                end else if (is_ctl && cond_true) begin
                    next_pc = target;
                end
            end
            ST_SLOT: begin
                next_pc = if_seq_pc;
            end
            default: begin
                next_pc = if_seq_pc;
            end
        endcase
    end

endmodule

// File: rtl/ibu_checker.sv
module ibu_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid,
    input logic [XLEN-1:0] if_pc,
    input logic            stall,
    input logic            redirect,
    input logic            link_we,
    input logic [XLEN-1:0] next_pc
);
    assert_stall_no_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !redirect);

    assert_stall_holds_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (next_pc == if_pc));

    assert_slot_never_redirects_R9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect);

    assert_link_with_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (redirect && !stall));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> (!redirect && !stall && !link_we));

endmodule

bind id_branch_unit ibu_checker #(.XLEN(XLEN)) u_ibu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_valid (id_valid),
    .if_pc    (if_pc),
    .stall    (stall),
    .redirect (redirect),
    .link_we  (link_we),
    .next_pc  (next_pc)
);

// File: tb/id_branch_unit_bench.sv
module id_branch_unit_bench;

    localparam time CLK_P = 5ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_valid = 1'b0;
    logic [31:0] id_instr = '0;
    logic [31:0] id_pc = '0;
    logic [31:0] if_pc = '0;
    logic [31:0] if_seq_pc = '0;
    logic [31:0] rs_val = '0;
    logic        ex_wr_en = 1'b0;
    logic [4:0]  ex_rd = '0;
    logic        mem_load = 1'b0;
    logic [4:0]  mem_rd = '0;
    logic [4:0]  rs_idx;
    logic        stall;
    logic        redirect;
    logic [31:0] next_pc;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    always #(CLK_P/2) clk = ~clk;

    id_branch_unit u_id_branch_unit (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
        .id_pc(id_pc), .if_pc(if_pc), .if_seq_pc(if_seq_pc), .rs_val(rs_val),
        .ex_wr_en(ex_wr_en), .ex_rd(ex_rd), .mem_load(mem_load), .mem_rd(mem_rd),
        .rs_idx(rs_idx), .stall(stall), .redirect(redirect), .next_pc(next_pc),
        .link_we(link_we), .link_idx(link_idx), .link_data(link_data)
    );

    typedef struct packed {
        logic        redirect;
        logic        stall;
        logic        link_we;
        logic [31:0] next_pc;
        logic [31:0] link_data;
        logic [4:0]  rs_idx;
        logic [31:0] tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    bit   slot_m = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input logic [31:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_br(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [15:0] imm);
        return {op, rs, 5'd0, imm};
    endfunction

    function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] ofs);
        return {op, ofs};
    endfunction

    // driver: applies one decode cycle and pushes the expectation
    task automatic apply(input logic v, input logic [31:0] ins, input logic [31:0] pc,
                         input logic [31:0] rv, input logic exw, input logic [4:0] exd,
                         input logic ml, input logic [4:0] md, input logic [31:0] tag);
        exp_t e;
        logic [5:0] op;
        logic [4:0] rs;
        logic ctl, br, haz, taken;
        logic [31:0] tgt;
        @(negedge clk);
        id_valid = v; id_instr = ins; id_pc = pc; if_pc = pc + 32'd4;
        if_seq_pc = pc + 32'd8; rs_val = rv; ex_wr_en = exw; ex_rd = exd;
        mem_load = ml; mem_rd = md;
        op  = ins[31:26];
        rs  = ins[25:21];
        ctl = v && !slot_m && (op == 6'h04 || op == 6'h05 || op == 6'h02 || op == 6'h03);
        br  = ctl && (op == 6'h04 || op == 6'h05);
        haz = br && (rs != 5'd0) && ((exw && exd == rs) || (ml && md == rs));
        taken = ctl && !haz && ((op == 6'h02) || (op == 6'h03) ||
                                (op == 6'h04 && rv == 32'd0) || (op == 6'h05 && rv != 32'd0));
        if (op == 6'h02 || op == 6'h03)
            tgt = pc + 32'd4 + {{6{ins[25]}}, ins[25:0]};
        else
            tgt = pc + 32'd4 + {{16{ins[15]}}, ins[15:0]};
        e.redirect  = taken;
        e.stall     = haz;
        e.link_we   = ctl && (op == 6'h03);
        e.next_pc   = haz ? pc + 32'd4 : (taken ? tgt : pc + 32'd8);
        e.link_data = pc + 32'd8;
        e.rs_idx    = rs;
        e.tag       = tag;
        exp_q.push_back(e);
        if (slot_m) begin
            if (v) slot_m = 1'b0;
        end else if (ctl && !haz) begin
            slot_m = 1'b1;
        end
    endtask

    // monitor: compares away from the clock edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(e.tag, "redirect", 32'(redirect), 32'(e.redirect));
                chk(e.tag, "stall", 32'(stall), 32'(e.stall));
                chk(e.tag, "next_pc", next_pc, e.next_pc);
                chk(e.tag, "link_we", 32'(link_we), 32'(e.link_we));
                chk(e.tag, "rs_idx", 32'(rs_idx), 32'(e.rs_idx));
                if (e.link_we) begin
                    chk(e.tag, "link_data", link_data, e.link_data);
                    chk(e.tag, "link_idx", 32'(link_idx), 32'd31);
                end
            end
        end
    end

    localparam logic [31:0] NOP = 32'h2000_0000;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset redirect", 32'(redirect), 32'd0);
        chk("R1", "reset stall", 32'(stall), 32'd0);
        rst_n = 1'b1;
        apply(0, NOP, 32'h100, 0, 0, 0, 0, 0, "R1");
        apply(0, NOP, 32'h104, 0, 0, 0, 0, 0, "R1");
        // non-control opcode
        apply(1, NOP, 32'h108, 0, 0, 0, 0, 0, "R2");
        apply(1, 32'h1C00_0004, 32'h10C, 0, 0, 0, 0, 0, "R2");
        // branch if zero, taken, negative offset; then slot
        apply(1, mk_br(6'h04, 5'd3, 16'hFFF0), 32'h200, 0, 0, 0, 0, 0, "R3");
        apply(1, NOP, 32'h204, 0, 0, 0, 0, 0, "R9");
        // branch if zero, not taken; slot holds a would-be-taken branch
        apply(1, mk_br(6'h04, 5'd4, 16'h0040), 32'h300, 32'd9, 0, 0, 0, 0, "R4");
        apply(1, mk_br(6'h04, 5'd4, 16'h0040), 32'h304, 32'd0, 0, 0, 0, 0, "R9");
        // branch if nonzero taken, then not taken
        apply(1, mk_br(6'h05, 5'd6, 16'h0100), 32'h400, 32'd1, 0, 0, 0, 0, "R4");
        apply(1, NOP, 32'h404, 0, 0, 0, 0, 0, "R9");
        apply(1, mk_br(6'h05, 5'd6, 16'h0100), 32'h500, 32'd0, 0, 0, 0, 0, "R4");
        apply(1, NOP, 32'h504, 0, 0, 0, 0, 0, "R9");
        // jump negative
        apply(1, mk_j(6'h02, 26'h3FF_FF00), 32'h1000, 0, 0, 0, 0, 0, "R5");
        apply(1, NOP, 32'h1004, 0, 0, 0, 0, 0, "R9");
        // jump and link, slot holds another jump and link
        apply(1, mk_j(6'h03, 26'h000_0200), 32'h2000, 0, 0, 0, 0, 0, "R6");
        apply(1, mk_j(6'h03, 26'h000_0200), 32'h2004, 0, 0, 0, 0, 0, "R9");
        // execute hazard for two cycles, then released and taken, slot branch ignored
        apply(1, mk_br(6'h05, 5'd7, 16'h0020), 32'h3000, 32'd5, 1, 5'd7, 0, 0, "R7");
        apply(1, mk_br(6'h05, 5'd7, 16'h0020), 32'h3000, 32'd5, 1, 5'd7, 0, 0, "R7");
        apply(1, mk_br(6'h05, 5'd7, 16'h0020), 32'h3000, 32'd5, 0, 0, 0, 0, "R7");
        apply(1, mk_br(6'h05, 5'd7, 16'h0020), 32'h3004, 32'd5, 0, 0, 0, 0, "R9");
        // load hazard in memory stage
        apply(1, mk_br(6'h04, 5'd9, 16'h0008), 32'h3100, 32'd0, 1, 5'd2, 1, 5'd9, "R7");
        apply(1, mk_br(6'h04, 5'd9, 16'h0008), 32'h3100, 32'd0, 1, 5'd2, 0, 5'd9, "R7");
        apply(1, NOP, 32'h3104, 0, 0, 0, 0, 0, "R9");
        // non-matching execute destination, no stall
        apply(1, mk_br(6'h04, 5'd10, 16'h0008), 32'h3200, 32'd0, 1, 5'd11, 0, 0, "R7");
        apply(1, NOP, 32'h3204, 0, 0, 0, 0, 0, "R9");
        // register zero never stalls
        apply(1, mk_br(6'h04, 5'd0, 16'h0010), 32'h3300, 32'd0, 1, 5'd0, 1, 5'd0, "R8");
        apply(1, NOP, 32'h3304, 0, 0, 0, 0, 0, "R9");
        // jump with matching bits 25:21 never stalls
        apply(1, mk_j(6'h02, {5'd12, 21'h40}), 32'h3400, 0, 1, 5'd12, 1, 5'd12, "R8");
        apply(1, NOP, 32'h3404, 0, 0, 0, 0, 0, "R9");
        // invalid decode with control opcode does nothing
        apply(0, mk_j(6'h03, 26'h10), 32'h3500, 0, 0, 0, 0, 0, "R10");
        apply(1, NOP, 32'h3500, 0, 0, 0, 0, 0, "R10");
        // pending slot survives invalid cycles
        apply(1, mk_br(6'h04, 5'd1, 16'h0004), 32'h3600, 32'd0, 0, 0, 0, 0, "R3");
        apply(0, NOP, 32'h3604, 0, 0, 0, 0, 0, "R10");
        apply(0, NOP, 32'h3604, 0, 0, 0, 0, 0, "R10");
        apply(1, mk_j(6'h02, 26'h80), 32'h3604, 0, 0, 0, 0, 0, "R10");
        apply(1, mk_j(6'h02, 26'h80), 32'h3700, 0, 0, 0, 0, 0, "R5");
        apply(1, NOP, 32'h3704, 0, 0, 0, 0, 0, "R9");
        apply(0, NOP, 32'h3708, 0, 0, 0, 0, 0, "R10");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule